// File: doc/BRIEF.md
# Banked Memory Mapper with Modes

This block sits between an 8-bit host processor with a 16-bit address bus and three memories: a program ROM, a work RAM with up to 18 physical address bits, and a 2 KB RAM shared with a second processor. For every memory cycle it decides which memory answers and forms the physical address, using only the address, the read/write direction and a few configuration fields. When no memory answers, it raises an unmapped flag. The block then supplies 0xFF to the processor on a read and blocks the strobe on a write.

The configuration lives in a small register file at I/O addresses 0xFC to 0xFF. A two-bit system mode chooses one of three complete maps, and mode 3 maps nothing. In the initial map, the first 16 KB is ROM. In the linear map, all of RAM shows through, with the shared RAM at the top 2 KB. In the ROM-language map, the 0x2000 window can show one of three ROM pages. In that map, a 4-bit bank field also steers the top 16 KB window through extended RAM or onto the shared RAM.

Top module: `bank_mapper`

## Requirements
- R1: Only I/O writes with io_addr[7:2] equal to 6'b111111 reach the register file, and io_addr[1:0] selects the register. Writes to any other I/O address leave the mapping unchanged.
- R2: Register 1 takes the mode from data[1:0]. Register 2 takes the top-window bank from data[7:4] and the ROM page from data[2:0]. Register 3 takes two flag bits from data[7] and data[6], which appear on ext_flags[1] and ext_flags[0]. Register 0 changes nothing. A register write takes effect on the rising clock edge that samples io_wr, and not before.
- R3: After reset, the mode, the bank, the ROM page and the flags are all zero.
- R4: In mode 0, a read of 0x0000–0x1FFF goes to ROM at 0x1000 + addr[11:0], and a read of 0x2000–0x3FFF goes to ROM at the same address. Any write below 0x4000 is unmapped. 0x4000–0xBFFF goes to RAM at the same address. In the top window, bank 0 goes to RAM 0xC000 + addr[13:0], bank 1 goes to RAM addr[13:0], and bank 15 goes to shared RAM at addr[10:0]. Any other bank there is unmapped.
- R5: In mode 1, 0xF800–0xFFFF goes to shared RAM at addr[10:0], and every other address goes to RAM at the same address. This holds for reads and for writes.
- R6: In mode 2, a read of 0x0000–0x1FFF goes to ROM at addr[12:0]. A read of 0x2000–0x3FFF goes to ROM at (page+1)*0x2000 + addr[12:0] when the page is 0, 1 or 2, and is unmapped for any other page. Writes below 0x4000 are unmapped, and 0x4000–0xBFFF goes to RAM at the same address.
- R7: In mode 2, the top window goes to RAM base 0x0C000 for bank 0 and to base 0 for bank 1. Banks 2 to 13 go to base 0x10000 + (bank−2)*0x4000, with addr[13:0] added to the base in every case. Bank 15 goes to shared RAM at addr[10:0], and bank 14 is unmapped.
- R8: Mode 3 maps nothing. Any unmapped access gives map_tgt 0 and phys_addr 0. The target codes are: 0 none, 1 ROM, 2 RAM, 3 shared.
- R9: cpu_rdata is 0xFF on an unmapped read. On a mapped read it equals tgt_rdata.
- R10: wr_en is 1 only for a mapped write, so an unmapped write is discarded.
- R11: io_rdata is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, always zero |
| mem_addr | input | 16 | Processor memory address |
| mem_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| tgt_rdata | input | 8 | Read data from the selected memory |
| map_tgt | output | 2 | Target: 0 none, 1 ROM, 2 RAM, 3 shared |
| phys_addr | output | 18 | Physical address inside the target |
| unmapped | output | 1 | No memory answers this access |
| cpu_rdata | output | 8 | Read data returned to the processor |
| wr_en | output | 1 | Write strobe to the selected memory |
| ext_flags | output | 2 | Flag bits from register 3 |

## Verification
A wrong mode, bank or page field shows up at the ports in the very next access cycle that touches an affected window. It appears as the wrong target code, a physical address in the wrong 16 KB or 8 KB page, or a false unmapped flag. A field that has been corrupted but is never consulted stays hidden until an access hits that window. For this reason, every configuration is checked at addresses on both sides of each window edge. A register update applied one edge too early or too late appears as the old or the new map at the single sample taken between the strobe and the edge.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_SHR  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] bank;
        logic [2:0] page;
        logic       flag_hi;
        logic       flag_lo;
    } cfg_t;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
    import bank_mapper_pkg::*;
#(
    parameter logic [7:0] IO_BASE = 8'hFC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_addr,
    input  logic [7:0] io_wdata,
    output cfg_t       cfg
);
    cfg_t cfg_d, cfg_q;
    logic sel;

    always_comb begin
        cfg_d = cfg_q;
        sel   = io_wr && (io_addr[7:2] == IO_BASE[7:2]);
        if (sel) begin
            case (io_addr[1:0])
                2'd1: cfg_d.mode = io_wdata[1:0];
                2'd2: begin
                    cfg_d.bank = io_wdata[7:4];
                    cfg_d.page = io_wdata[2:0];
                end
                2'd3: begin
                    cfg_d.flag_hi = io_wdata[7];
                    cfg_d.flag_lo = io_wdata[6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bank_decode.sv
module bank_decode
    import bank_mapper_pkg::*;
#(
    parameter int PHYS_W = 18
) (
    input  cfg_t              cfg,
    input  logic [15:0]       addr,
    input  logic              wr,
    output tgt_e              tgt,
    output logic [PHYS_W-1:0] phys,
    output logic              unm
);
    localparam int BANK_W = PHYS_W - 14;
    localparam int PAGE_W = PHYS_W - 13;

    logic [1:0] quad;
    logic       top_shr;

    assign quad    = addr[15:14];
    assign top_shr = (addr[15:11] == 5'h1F);

    always_comb begin
        tgt  = TGT_NONE;
        phys = '0;
        case (cfg.mode)
            2'd0: begin
                if (quad == 2'd0) begin
                    if (!wr) begin
                        tgt  = TGT_ROM;
                        phys = addr[13] ? PHYS_W'(addr) : PHYS_W'({4'h1, addr[11:0]});
                    end
                end else if (quad != 2'd3) begin
                    tgt  = TGT_RAM;
                    phys = PHYS_W'(addr);
                end else begin
                    case (cfg.bank)
                        4'd0: begin tgt = TGT_RAM; phys = {BANK_W'(3), addr[13:0]}; end
                        4'd1: begin tgt = TGT_RAM; phys = {BANK_W'(0), addr[13:0]}; end
                        4'd15: begin tgt = TGT_SHR; phys = PHYS_W'(addr[10:0]); end
                        default: ;
                    endcase
                end
            end
            2'd1: begin
                if (top_shr) begin
                    tgt  = TGT_SHR;
                    phys = PHYS_W'(addr[10:0]);
                end else begin
                    tgt  = TGT_RAM;
                    phys = PHYS_W'(addr);
                end
            end
            2'd2: begin
                if (quad == 2'd0) begin
                    if (!wr) begin
                        if (!addr[13]) begin
                            tgt  = TGT_ROM;
                            phys = PHYS_W'(addr[12:0]);
                        end else if (cfg.page < 3'd3) begin
                            tgt  = TGT_ROM;
                            phys = {PAGE_W'(cfg.page) + PAGE_W'(1), addr[12:0]};
                        end
                    end
                end else if (quad != 2'd3) begin
                    tgt  = TGT_RAM;
                    phys = PHYS_W'(addr);
                end else begin
                    case (cfg.bank)
                        4'd0:  begin tgt = TGT_RAM; phys = {BANK_W'(3), addr[13:0]}; end
                        4'd1:  begin tgt = TGT_RAM; phys = {BANK_W'(0), addr[13:0]}; end
                        4'd14: ;
                        4'd15: begin tgt = TGT_SHR; phys = PHYS_W'(addr[10:0]); end
                        default: begin
                            tgt  = TGT_RAM;
                            phys = {BANK_W'(cfg.bank) + BANK_W'(2), addr[13:0]};
                        end
                    endcase
                end
            end
            default: ;
        endcase
        unm = (tgt == TGT_NONE);
    end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter logic [7:0] IO_BASE = 8'hFC,
    parameter int         PHYS_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [15:0]       mem_addr,
    input  logic              mem_wr,
    input  logic [7:0]        tgt_rdata,
    output logic [1:0]        map_tgt,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              unmapped,
    output logic [7:0]        cpu_rdata,
    output logic              wr_en,
    output logic [1:0]        ext_flags
);
    cfg_t cfg;
    tgt_e tgt;

    bank_cfg_regs #(.IO_BASE(IO_BASE)) regs_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .cfg(cfg)
    );

    bank_decode #(.PHYS_W(PHYS_W)) dec_i (
        .cfg(cfg), .addr(mem_addr), .wr(mem_wr),
        .tgt(tgt), .phys(phys_addr), .unm(unmapped)
    );

    assign map_tgt   = tgt;
    assign cpu_rdata = unmapped ? 8'hFF : tgt_rdata;
    assign wr_en     = mem_wr && !unmapped;
    assign io_rdata  = 8'h00;
    assign ext_flags = {cfg.flag_hi, cfg.flag_lo};
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter int PHYS_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic [7:0]        io_addr,
    input logic [7:0]        io_wdata,
    input logic [15:0]       mem_addr,
    input logic              mem_wr,
    input logic [7:0]        tgt_rdata,
    input logic [1:0]        map_tgt,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              unmapped,
    input logic [7:0]        cpu_rdata,
    input logic              wr_en,
    input logic [1:0]        ext_flags
);
    // R8
    none_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (map_tgt == 2'd0 && phys_addr == '0));
    // R9
    ff_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped && !mem_wr) |-> (cpu_rdata == 8'hFF));
    // R10
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (mem_wr && map_tgt != 2'd0));
    // R5
    shared_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_tgt == 2'd3) |-> (phys_addr[PHYS_W-1:11] == '0 && phys_addr[10:0] == mem_addr[10:0]));
    // R4
    mid_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_tgt == 2'd2 && (mem_addr[15:14] == 2'd1 || mem_addr[15:14] == 2'd2))
        |-> (phys_addr == PHYS_W'(mem_addr)));
    // R2
    flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 8'hFF) |=> (ext_flags == $past(io_wdata[7:6])));
endmodule

bind bank_mapper bank_mapper_chk #(.PHYS_W(PHYS_W)) chk_i (.*);

// File: tb/bank_mapper_tb.sv
`timescale 1ns/1ps
module bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] mem_addr = 16'h0000;
    logic        mem_wr = 1'b0;
    logic [7:0]  tgt_rdata = 8'h5A;
    logic [1:0]  map_tgt;
    logic [17:0] phys_addr;
    logic        unmapped;
    logic [7:0]  cpu_rdata;
    logic        wr_en;
    logic [1:0]  ext_flags;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .tgt_rdata(tgt_rdata), .map_tgt(map_tgt),
        .phys_addr(phys_addr), .unmapped(unmapped), .cpu_rdata(cpu_rdata),
        .wr_en(wr_en), .ext_flags(ext_flags)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 200000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // expected {unmapped, target, phys} from the requirements
    function automatic logic [20:0] model(input int mode, input int bank, input int page,
                                          input int a, input bit w);
        int t = 0;
        int p = 0;
        int q = a / 'h4000;
        if (mode == 0 || mode == 2) begin
            if (q == 0) begin
                if (!w) begin
                    if (mode == 0) begin
                        t = 1; p = (a < 'h2000) ? ('h1000 + a % 'h1000) : a;
                    end else if (a < 'h2000) begin
                        t = 1; p = a;
                    end else if (page <= 2) begin
                        t = 1; p = (page + 1) * 'h2000 + a % 'h2000;
                    end
                end
            end else if (q != 3) begin
                t = 2; p = a;
            end else if (bank == 15) begin
                t = 3; p = a % 'h800;
            end else if (bank == 0) begin
                t = 2; p = 'hC000 + a % 'h4000;
            end else if (bank == 1) begin
                t = 2; p = a % 'h4000;
            end else if (mode == 2 && bank <= 13) begin
                t = 2; p = 'h10000 + (bank - 2) * 'h4000 + a % 'h4000;
            end
        end else if (mode == 1) begin
            if (a >= 'hF800) begin t = 3; p = a % 'h800; end
            else begin t = 2; p = a; end
        end
        return {(t == 0), 2'(t), 18'(p)};
    endfunction

    task automatic probe(input string req, input int mode, input int bank, input int page,
                         input int a, input bit w);
        logic [20:0] e;
        mem_addr = 16'(a); mem_wr = w;
        #1;
        e = model(mode, bank, page, a, w);
        chk(req, {11'd0, unmapped, map_tgt, phys_addr}, {11'd0, e});
        if (!w) chk("R9", {24'd0, cpu_rdata}, {24'd0, (e[20] ? 8'hFF : 8'h5A)});
        else    chk("R10", {31'd0, wr_en}, {31'd0, ~e[20]});
    endtask

    int addrs [16] = '{'h0000, 'h0FFF, 'h1000, 'h1FFF, 'h2000, 'h3FFF, 'h4000, 'h7FFF,
                       'h8000, 'hBFFF, 'hC000, 'hF7FF, 'hF800, 'hFFFF, 'h2ABC, 'hDEAD};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state seen through the map and flags
        chk("R3", {30'd0, ext_flags}, 32'd0);
        probe("R3", 0, 0, 0, 'h0000, 1'b0);
        probe("R3", 0, 0, 0, 'hC123, 1'b0);
        probe("R3", 0, 0, 0, 'h2345, 1'b0);
        chk("R11", {24'd0, io_rdata}, 32'd0);

        // R1: near miss port ignored
        io_write(8'hF9, 8'h01);
        probe("R1", 0, 0, 0, 'h0000, 1'b0);
        io_write(8'h7D, 8'h02);
        probe("R1", 0, 0, 0, 'h0000, 1'b0);
        // R2: register 0 changes nothing
        io_write(8'hFC, 8'hFF);
        probe("R2", 0, 0, 0, 'hF900, 1'b0);
        probe("R2", 0, 0, 0, 'h0010, 1'b0);
        // R2: flags
        io_write(8'hFF, 8'h80);
        chk("R2", {30'd0, ext_flags}, 32'd2);
        io_write(8'hFF, 8'h40);
        chk("R2", {30'd0, ext_flags}, 32'd1);
        // R2: update timing, old map before the edge, new map after
        @(negedge clk);
        io_wr = 1'b1; io_addr = 8'hFD; io_wdata = 8'h01;
        probe("R2", 0, 0, 0, 'h0000, 1'b0);
        @(negedge clk);
        io_wr = 1'b0;
        probe("R2", 1, 0, 0, 'h0000, 1'b0);
        chk("R11", {24'd0, io_rdata}, 32'd0);

        // sweep of every mode, bank and page over window edges
        for (int m = 0; m < 4; m++) begin
            io_write(8'hFD, 8'(m));
            for (int b = 0; b < 16; b++) begin
                for (int g = 0; g < 8; g++) begin
                    io_write(8'hFE, {4'(b), 1'b1, 3'(g)});
                    for (int i = 0; i < 16; i++) begin
                        for (int w = 0; w < 2; w++) begin
                            case (m)
                                0: probe("R4", m, b, g, addrs[i], w[0]);
                                1: probe("R5", m, b, g, addrs[i], w[0]);
                                2: probe((addrs[i] >= 'hC000) ? "R7" : "R6", m, b, g, addrs[i], w[0]);
                                default: probe("R8", m, b, g, addrs[i], w[0]);
                            endcase
                        end
                    end
                end
            end
        end
        chk("R2", {30'd0, ext_flags}, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule